// File: doc/BRIEF.md
# Combination Lock Controller with Failure Backoff

This block checks a keyed combination. Digits arrive one at a time as 4-bit BCD values, each marked by a one-cycle strobe. After a fixed number of digits the block compares the whole entry against a configured code. A correct entry pulses the actuator enable for a timed window.

A wrong entry raises a failure count and imposes a lockout. The lockout grows longer with each further failure, up to a ceiling. Once the count reaches the failure limit, the block enters a blocked state. It leaves that state on an administrator reset or after a long cooldown.

All durations are counted in whole seconds from a one-cycle timebase tick supplied by the surrounding logic. The remaining seconds of the active countdown are visible on an output. That countdown is the key timeout, the open window, the lockout or the cooldown, depending on the state.

Top module: `combo_lock_backoff`

## Requirements
- R1: After reset the state output is IDLE, the actuator enable is low, the remaining seconds are 0 and the failure count is 0.
- R2: A digit strobe in IDLE moves the block to INPUT and sets the remaining seconds to 5. Each further digit that does not complete the entry reloads the remaining seconds to 5.
- R3: In INPUT, if five ticks pass with no digit, the block returns to IDLE. The partial entry is discarded and the failure count is unchanged.
- R4: The fourth digit completes the entry, packed with the first digit in bits 15:12 and the last in bits 3:0, and it is compared with the code in that cycle. On a match the block enters ACCEPT with the actuator enable high and the remaining seconds at 2. Digits are ignored in ACCEPT, and after two ticks the block returns to IDLE.
- R5: A mismatch increments the failure count. The first failure gives a 3 s lockout. A later failure n gives min(5·2^(n−1), 300) s. The remaining seconds drop by one on each tick.
- R6: During a lockout, digits and the admin reset have no effect. When the lockout expires, the block returns to IDLE with an empty entry.
- R7: The mismatch that brings the failure count to 5 enters BLOCKED, with the remaining seconds at 600, instead of a lockout.
- R8: BLOCKED is left either by an admin reset or by 600 ticks. Either path clears the failure count and returns to IDLE.
- R9: When the ACCEPT window ends, the failure count is cleared.
- R10: An admin reset in IDLE clears the failure count.
- R11: The state codes are IDLE=0, INPUT=1, ACCEPT=2, PENALTY=3 and BLOCKED=4. Any other code returns to IDLE with the entry cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_i | input | 4 | BCD digit value |
| digit_vld_i | input | 1 | One-cycle digit strobe |
| admin_rst_i | input | 1 | Administrator reset request |
| tick_1s_i | input | 1 | One-cycle pulse once per second |
| code_i | input | 16 | Configured combination, first digit in the top nibble |
| actuate_o | output | 1 | Actuator enable, high throughout ACCEPT |
| state_o | output | 3 | Current state code |
| remain_o | output | 10 | Seconds left on the active countdown |
| fail_cnt_o | output | 3 | Consecutive failure count |

## Verification
The assertions assume that the strobe, the tick and the admin reset are single-cycle pulses that are synchronous to the clock. They also assume that the code stays stable while an entry is in progress. The stimulus raises each pulse for exactly one cycle, launched on the falling edge. It never changes the code during a run, and it never sends a tick in the same cycle as a digit. This keeps the priority between a completing digit and an expiring key timer out of the checked behaviour.

// File: rtl/lock_pkg.sv
package lock_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_INPUT   = 3'd1,
      ST_ACCEPT  = 3'd2,
      ST_PENALTY = 3'd3,
      ST_BLOCKED = 3'd4
   } lock_st_e;

   // Lockout length for the n-th failure: a short first step, then doubling up to a ceiling.
   function automatic int unsigned backoff_secs(int unsigned nfail, int unsigned first_s,
                                                int unsigned base_s, int unsigned ceil_s);
      int unsigned v;
      if (nfail <= 1) return first_s;
      if (nfail > 20) return ceil_s;
      v = base_s << (nfail - 1);
      return (v > ceil_s) ? ceil_s : v;
   endfunction

endpackage

// File: rtl/entry_buffer.sv
module entry_buffer #(
   parameter int DIGITS = 4,
   parameter int DW     = 4,
   localparam int CW    = $clog2(DIGITS + 1),
   localparam int EW    = DIGITS * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          push_i,
   input  logic [DW-1:0] digit_i,
   output logic          last_o,
   output logic [EW-1:0] packed_o
);

   if (DIGITS < 2) begin : g_bad_digits
      $error("entry_buffer: DIGITS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] slot_q [DIGITS-1];

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)  cnt_q <= '0;
      else if (push_i)      cnt_q <= cnt_q + 1'b1;
   end

   // slot 0 holds the newest digit; older digits shift toward the top slot
   for (genvar i = 0; i < DIGITS - 1; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) slot_q[i] <= '0;
         else if (push_i) begin
            if (i == 0) slot_q[i] <= digit_i;
            else        slot_q[i] <= slot_q[(i == 0) ? 0 : i - 1];
         end
      end
      assign packed_o[(i+1)*DW +: DW] = slot_q[i];
   end

   assign packed_o[DW-1:0] = digit_i;
   assign last_o           = (cnt_q == CW'(DIGITS - 1));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DIGITS - 1));

endmodule

// File: rtl/sec_timer.sv
module sec_timer #(
   parameter int TW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   input  logic          tick_i,
   output logic [TW-1:0] remain_o,
   output logic          expire_o
);

   logic [TW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                            remain_q <= '0;
      else if (load_i)                       remain_q <= load_val_i;
      else if (tick_i && remain_q != '0)     remain_q <= remain_q - 1'b1;
   end

   assign remain_o = remain_q;
   assign expire_o = tick_i && !load_i && (remain_q == TW'(1));

   p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(remain_q));

endmodule

// File: rtl/penalty_calc.sv
module penalty_calc #(
   parameter int FAIL_W  = 3,
   parameter int TW      = 10,
   parameter int FIRST_S = 3,
   parameter int BASE_S  = 5,
   parameter int CEIL_S  = 300,
   localparam int NF     = 2 ** FAIL_W
) (
   input  logic [FAIL_W-1:0] fail_i,
   output logic [TW-1:0]     secs_o
);

   if (CEIL_S >= 2 ** TW || FIRST_S >= 2 ** TW) begin : g_bad_width
      $error("penalty_calc: TW too narrow for lockout lengths");
   end

   logic [TW-1:0] lut [NF];

   for (genvar f = 0; f < NF; f++) begin : g_lut
      assign lut[f] = TW'(lock_pkg::backoff_secs(f, FIRST_S, BASE_S, CEIL_S));
   end

   assign secs_o = lut[fail_i];

endmodule

// File: rtl/combo_lock_backoff.sv
module combo_lock_backoff #(
   parameter int DIGITS     = 4,
   parameter int DW         = 4,
   parameter int FAIL_W     = 3,
   parameter int FAIL_LIMIT = 5,
   parameter int TW         = 10,
   parameter int KEY_TO_S   = 5,
   parameter int OPEN_S     = 2,
   parameter int FIRST_S    = 3,
   parameter int BASE_S     = 5,
   parameter int CEIL_S     = 300,
   parameter int BLOCK_S    = 600,
   localparam int EW        = DIGITS * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     digit_i,
   input  logic              digit_vld_i,
   input  logic              admin_rst_i,
   input  logic              tick_1s_i,
   input  logic [EW-1:0]     code_i,
   output logic              actuate_o,
   output logic [2:0]        state_o,
   output logic [TW-1:0]     remain_o,
   output logic [FAIL_W-1:0] fail_cnt_o
);
   import lock_pkg::*;

   if (FAIL_LIMIT < 1 || FAIL_LIMIT >= 2 ** FAIL_W) begin : g_bad_limit
      $error("combo_lock_backoff: FAIL_LIMIT does not fit FAIL_W");
   end
   if (BLOCK_S >= 2 ** TW || KEY_TO_S >= 2 ** TW || OPEN_S >= 2 ** TW) begin : g_bad_tw
      $error("combo_lock_backoff: TW too narrow for durations");
   end
   if (KEY_TO_S < 1 || OPEN_S < 1 || BLOCK_S < 1) begin : g_bad_dur
      $error("combo_lock_backoff: durations must be nonzero");
   end

   lock_st_e          st_q, st_d;
   logic [FAIL_W-1:0] fail_q, fail_d, fail_inc;
   logic              buf_clr, buf_push, buf_last;
   logic [EW-1:0]     entry_w;
   logic              tmr_load, tmr_exp;
   logic [TW-1:0]     tmr_val, pen_w;
   logic              match_w;

   entry_buffer #(.DIGITS(DIGITS), .DW(DW)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .push_i(buf_push),
      .digit_i(digit_i), .last_o(buf_last), .packed_o(entry_w));

   sec_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
      .tick_i(tick_1s_i), .remain_o(remain_o), .expire_o(tmr_exp));

   penalty_calc #(.FAIL_W(FAIL_W), .TW(TW), .FIRST_S(FIRST_S),
                  .BASE_S(BASE_S), .CEIL_S(CEIL_S)) u_pen (
      .fail_i(fail_inc), .secs_o(pen_w));

   assign fail_inc = fail_q + 1'b1;
   assign match_w  = (entry_w == code_i);

   always_comb begin
      st_d     = st_q;
      fail_d   = fail_q;
      buf_clr  = 1'b0;
      buf_push = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st_q)
         ST_IDLE: begin
            if (admin_rst_i) fail_d = '0;
            if (digit_vld_i) begin
               buf_push = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TW'(KEY_TO_S);
               st_d     = ST_INPUT;
            end
         end
         ST_INPUT: begin
            if (digit_vld_i) begin
               tmr_load = 1'b1;
               if (buf_last) begin
                  buf_clr = 1'b1;
                  if (match_w) begin
                     st_d    = ST_ACCEPT;
                     tmr_val = TW'(OPEN_S);
                  end else begin
                     fail_d = fail_inc;
                     if (fail_inc == FAIL_W'(FAIL_LIMIT)) begin
                        st_d    = ST_BLOCKED;
                        tmr_val = TW'(BLOCK_S);
                     end else begin
                        st_d    = ST_PENALTY;
                        tmr_val = pen_w;
                     end
                  end
               end else begin
                  buf_push = 1'b1;
                  tmr_val  = TW'(KEY_TO_S);
               end
            end else if (tmr_exp) begin
               buf_clr = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_ACCEPT: begin
            if (tmr_exp) begin
               fail_d  = '0;
               buf_clr = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_PENALTY: begin
            if (tmr_exp) begin
               buf_clr = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_BLOCKED: begin
            if (admin_rst_i) begin
               fail_d   = '0;
               buf_clr  = 1'b1;
               tmr_load = 1'b1;
               st_d     = ST_IDLE;
            end else if (tmr_exp) begin
               fail_d  = '0;
               buf_clr = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         default: begin
            buf_clr  = 1'b1;
            tmr_load = 1'b1;
            st_d     = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fail_q <= '0;
      end else begin
         st_q   <= st_d;
         fail_q <= fail_d;
      end
   end

   assign actuate_o  = (st_q == ST_ACCEPT);
   assign state_o    = st_q;
   assign fail_cnt_o = fail_q;

   p_fail_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail_cnt_o <= FAIL_W'(FAIL_LIMIT));

   p_blocked_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd4) |-> (fail_cnt_o == FAIL_W'(FAIL_LIMIT)));

   p_open_needs_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(actuate_o) |-> $past(digit_vld_i));

   p_timeout_keeps_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 && !digit_vld_i) |=> $stable(fail_cnt_o));

   p_lockout_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 && st_d == ST_PENALTY) |=> (remain_o == $past(pen_w)));

   p_locked_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 3'd3 || state_o == 3'd2) && !tick_1s_i) |=>
         ($stable(state_o) && $stable(fail_cnt_o)));

   p_open_end_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(actuate_o) |-> (fail_cnt_o == '0));

   p_legal_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd4);

endmodule

// File: tb/tb_combo_lock_backoff.sv
module tb_combo_lock_backoff;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] digit_i = '0;
   logic       digit_vld_i = 1'b0;
   logic       admin_rst_i = 1'b0;
   logic       tick_1s_i = 1'b0;
   logic [15:0] code_i = 16'h1234;
   logic       actuate_o;
   logic [2:0] state_o;
   logic [9:0] remain_o;
   logic [2:0] fail_cnt_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   combo_lock_backoff dut (
      .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .digit_vld_i(digit_vld_i),
      .admin_rst_i(admin_rst_i), .tick_1s_i(tick_1s_i), .code_i(code_i),
      .actuate_o(actuate_o), .state_o(state_o), .remain_o(remain_o),
      .fail_cnt_o(fail_cnt_o));

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_all(string req, int st, int act, int rem, int fl);
      check(req, "state", state_o, st);
      check(req, "actuate", actuate_o, act);
      check(req, "remain", remain_o, rem);
      check(req, "fail", fail_cnt_o, fl);
   endtask

   task automatic press(input logic [3:0] d);
      @(negedge clk); digit_i = d; digit_vld_i = 1'b1;
      @(negedge clk); digit_vld_i = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1s_i = 1'b1;
         @(negedge clk); tick_1s_i = 1'b0;
      end
   endtask

   task automatic admin();
      @(negedge clk); admin_rst_i = 1'b1;
      @(negedge clk); admin_rst_i = 1'b0;
   endtask

   task automatic enter(input logic [3:0] a, b, c, d);
      press(a); press(b); press(c); press(d);
   endtask

   task automatic t_reset();
      expect_all("R1", 0, 0, 0, 0);
      check("R11", "idle code", state_o, 0);
   endtask

   task automatic t_accept();
      press(4'd1);
      check("R2", "state after first digit", state_o, 1);
      check("R2", "remain after first digit", remain_o, 5);
      tick_n(1);
      check("R2", "remain after tick", remain_o, 4);
      press(4'd2);
      check("R2", "remain reloaded", remain_o, 5);
      press(4'd3); press(4'd4);
      expect_all("R4", 2, 1, 2, 0);
      press(4'd7);
      check("R4", "digit ignored state", state_o, 2);
      check("R4", "digit ignored remain", remain_o, 2);
      tick_n(1);
      check("R4", "still open", actuate_o, 1);
      tick_n(1);
      expect_all("R4", 0, 0, 0, 0);
   endtask

   task automatic t_order_and_lockout();
      enter(4'd4, 4'd3, 4'd2, 4'd1);
      expect_all("R5", 3, 0, 3, 1);
      press(4'd9);
      check("R6", "digit in lockout state", state_o, 3);
      check("R6", "digit in lockout fail", fail_cnt_o, 1);
      check("R6", "digit in lockout remain", remain_o, 3);
      admin();
      check("R6", "admin in lockout state", state_o, 3);
      check("R6", "admin in lockout fail", fail_cnt_o, 1);
      tick_n(2);
      check("R5", "lockout count", remain_o, 1);
      tick_n(1);
      check("R6", "lockout expiry", state_o, 0);
   endtask

   task automatic t_backoff_admin();
      enter(4'd9, 4'd9, 4'd9, 4'd9);
      expect_all("R5", 3, 0, 10, 2);
      tick_n(10);
      enter(4'd9, 4'd9, 4'd9, 4'd9);
      expect_all("R5", 3, 0, 20, 3);
      tick_n(20);
      enter(4'd9, 4'd9, 4'd9, 4'd9);
      expect_all("R5", 3, 0, 40, 4);
      tick_n(40);
      enter(4'd9, 4'd9, 4'd9, 4'd9);
      expect_all("R7", 4, 0, 600, 5);
      press(4'd1);
      check("R7", "digit in blocked", state_o, 4);
      admin();
      check("R8", "admin leaves blocked", state_o, 0);
      check("R8", "admin clears fail", fail_cnt_o, 0);
   endtask

   task automatic t_timeout();
      enter(4'd5, 4'd5, 4'd5, 4'd5);
      check("R5", "first failure lockout", remain_o, 3);
      tick_n(3);
      press(4'd5); press(4'd6);
      tick_n(4);
      check("R3", "before timeout state", state_o, 1);
      check("R3", "before timeout remain", remain_o, 1);
      tick_n(1);
      check("R3", "timeout to idle", state_o, 0);
      check("R3", "timeout keeps fail", fail_cnt_o, 1);
      enter(4'd1, 4'd2, 4'd3, 4'd4);
      check("R3", "entry discarded, fresh match", state_o, 2);
      check("R9", "fail held while open", fail_cnt_o, 1);
      tick_n(2);
      check("R9", "open end clears fail", fail_cnt_o, 0);
   endtask

   task automatic t_admin_idle();
      enter(4'd0, 4'd0, 4'd0, 4'd0);
      tick_n(3);
      check("R10", "fail before admin", fail_cnt_o, 1);
      admin();
      check("R10", "admin in idle clears fail", fail_cnt_o, 0);
      check("R10", "admin in idle state", state_o, 0);
   endtask

   task automatic t_cooldown();
      int pens[4] = '{3, 10, 20, 40};
      for (int k = 0; k < 4; k++) begin
         enter(4'd8, 4'd8, 4'd8, 4'd8);
         tick_n(pens[k]);
      end
      enter(4'd8, 4'd8, 4'd8, 4'd8);
      check("R7", "blocked again", state_o, 4);
      tick_n(599);
      check("R8", "cooldown remain", remain_o, 1);
      check("R8", "cooldown still blocked", state_o, 4);
      tick_n(1);
      check("R8", "cooldown exit state", state_o, 0);
      check("R8", "cooldown clears fail", fail_cnt_o, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_accept();
      t_order_and_lockout();
      t_backoff_admin();
      t_timeout();
      t_admin_idle();
      t_cooldown();
      finish_run();
   end

endmodule